// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block keeps the program counter pair of a 32-bit pipeline that has one architectural delay slot after every control transfer. It holds the address being fetched now and the address queued behind it. When an instruction retires, the decoder presents a control-flow class, the 16-bit immediate, the 26-bit jump index, a register-supplied address, the outcome of the branch test and an exception request. The sequencer then shifts the queued address into the fetch position and computes the address that follows it.

Several kinds of transfer are handled. Conditional branches are relative to the delay-slot address. "Likely" branches cancel their delay slot when they are not taken. Absolute jumps keep the top nibble of the delay-slot address. Register jumps take the supplied address. Exception entry goes to a fixed vector, cancels the following instruction and captures a return address whose bit 1 flags a faulting instruction that sat in a delay slot. The block also presents the return address that link-form transfers write to the link register.

Top module: `pcseq_top`

## Requirements
- R1: After reset the fetch address is 0x00000000, the queued address is 0x00000004, annul is low and the captured return address is 0x00000000.
- R2: On a step the fetch address takes the old queued address, and with no redirect the queued address becomes the old queued address plus 4. Without a step, neither address changes.
- R3: A conditional branch (class 1) with its test true sets the queued address to (old queued + 4) + (sign-extended immediate << 2) - 4. With the test false, it sequences as in R2.
- R4: A likely branch (class 2) redirects like R3 when its test is true. When its test is false it raises annul for exactly the next step.
- R5: An absolute jump (class 3) sets the queued address to {bits 31:28 of the old queued address, jump index, 2'b00}.
- R6: A register jump (class 4) sets the queued address to the register address with its two low bits cleared. Class 0 is plain sequencing.
- R7: The queued address always has bits 1:0 equal to 0.
- R8: An exception on a step that is not annulled captures (fetch + 4) as the return address, ORed with 2 when the queued address is not fetch + 4. It sets the queued address to 0x0000003C and raises annul for the next step. Exception entry takes priority over any redirect.
- R9: On an annulled step, class, test and exception inputs are ignored: the queued address advances by 4, the return address is kept, and annul falls.
- R10: The link output always equals the queued address plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | One instruction retires this cycle |
| cls_i | input | 3 | Control class: 0 seq, 1 branch, 2 likely branch, 3 absolute jump, 4 register jump |
| cond_i | input | 1 | Branch test outcome |
| imm_i | input | 16 | Branch offset in words |
| jidx_i | input | 26 | Absolute jump word index |
| jreg_i | input | 32 | Register jump address |
| exc_i | input | 1 | Exception raised by the retiring instruction |
| fetch_pc_o | output | 32 | Address being fetched |
| next_pc_o | output | 32 | Queued address |
| annul_o | output | 1 | Instruction at fetch address must not execute |
| epc_o | output | 32 | Captured return address with delay-slot flag in bit 1 |
| link_o | output | 32 | Return address for link-form transfers |

## Verification
The hardest situation to reach from the ports is an instruction that is both annulled and carrying an exception request and a redirect class. The input must be ignored, and the return address must not move. The stimulus first issues a likely branch with a false test, then drives the cancelled step with an exception and a register jump together. The delay-slot flag of the return address is reached by raising an exception on the step right after a taken branch, and it is contrasted with an exception on straight-line code.

// File: rtl/pcseq_pkg.sv
// Shared widths, class codes and the exception vector for the PC sequencer.
package pcseq_pkg;
    localparam int unsigned AW      = 32;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned JIDX_W  = 26;
    localparam int unsigned CLS_W   = 3;
    localparam logic [AW-1:0] EXC_VEC = 32'h0000_003C;

    typedef enum logic [CLS_W-1:0] {
        CLS_SEQ  = 3'd0,
        CLS_BR   = 3'd1,
        CLS_BRL  = 3'd2,
        CLS_JABS = 3'd3,
        CLS_JREG = 3'd4
    } cls_e;
endpackage

// File: rtl/pcseq_target.sv
// Target resolver: picks the redirect address and redirect/annul requests
// for one retiring instruction. Assumes the caller gates it when annulled.
module pcseq_target
    import pcseq_pkg::*;
(
    input  logic [AW-1:0]     slot_pc,
    input  logic [AW-1:0]     seq_pc,
    input  logic [AW-1:0]     jreg,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JIDX_W-1:0] jidx,
    input  logic [CLS_W-1:0]  cls,
    input  logic              cond,
    output logic              redirect,
    output logic              annul_req,
    output logic [AW-1:0]     target
);
    localparam int unsigned SEXT_W = AW - IMM_W - 2;
    localparam int unsigned TOP_W  = AW - JIDX_W - 2;

    logic [AW-1:0] br_off;
    logic [AW-1:0] br_tgt;
    logic [AW-1:0] ja_tgt;

    // Branch offset is word-scaled, sign-extended, relative to the slot.
    assign br_off = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    assign br_tgt = seq_pc + br_off - AW'(4);
    assign ja_tgt = {slot_pc[AW-1 -: TOP_W], jidx, 2'b00};

    // Choose redirect address per class.
    always_comb begin
        redirect  = 1'b0;
        annul_req = 1'b0;
        target    = seq_pc;
        unique case (cls_e'(cls))
            CLS_BR: begin
                redirect = cond;
                target   = br_tgt;
            end
            CLS_BRL: begin
                redirect  = cond;
                annul_req = ~cond;
                target    = br_tgt;
            end
            CLS_JABS: begin
                redirect = 1'b1;
                target   = ja_tgt;
            end
            CLS_JREG: begin
                redirect = 1'b1;
                target   = jreg;
            end
            default: begin
                redirect = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pcseq_epc.sv
// Return-address capture: forms fetch+4 with a delay-slot flag in bit 1
// and stores it when an exception is accepted. Assumes AW >= 2.
module pcseq_epc
    import pcseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] queued_pc,
    output logic [AW-1:0] epc
);
    logic [AW-1:0] fall;
    logic          in_slot;

    assign fall    = cur_pc + AW'(4);
    assign in_slot = (queued_pc != fall);

    // Latch the return address on exception entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc <= '0;
        else if (take)
            epc <= fall | {{(AW-2){1'b0}}, in_slot, 1'b0};
    end
endmodule

// File: rtl/pcseq_top.sv
// Delay-slot next-PC sequencer top. Holds fetch/queued addresses and the
// annul flag; each step shifts queued into fetch and resolves the follower.
// Assumes at most one step per cycle and decoded inputs valid with step_i.
module pcseq_top
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic              cond_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [JIDX_W-1:0] jidx_i,
    input  logic [AW-1:0]     jreg_i,
    input  logic              exc_i,
    output logic [AW-1:0]     fetch_pc_o,
    output logic [AW-1:0]     next_pc_o,
    output logic              annul_o,
    output logic [AW-1:0]     epc_o,
    output logic [AW-1:0]     link_o
);
    logic [AW-1:0] pc_q, npc_q, npc_d, seq_pc, tgt;
    logic          skip_q, skip_d;
    logic          redir, annul_req, live, exc_take;

    assign seq_pc   = npc_q + AW'(4);
    assign live     = step_i & ~skip_q;
    assign exc_take = live & exc_i;

    pcseq_target u_target (
        .slot_pc  (npc_q),
        .seq_pc   (seq_pc),
        .jreg     (jreg_i),
        .imm      (imm_i),
        .jidx     (jidx_i),
        .cls      (cls_i),
        .cond     (cond_i),
        .redirect (redir),
        .annul_req(annul_req),
        .target   (tgt)
    );

    pcseq_epc u_epc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (exc_take),
        .cur_pc   (pc_q),
        .queued_pc(npc_q),
        .epc      (epc_o)
    );

    // Resolve follower address and annul flag; exception wins.
    always_comb begin
        npc_d  = seq_pc;
        skip_d = 1'b0;
        if (exc_take) begin
            npc_d  = EXC_VEC;
            skip_d = 1'b1;
        end else if (live) begin
            if (redir) npc_d = tgt;
            skip_d = annul_req;
        end
        npc_d[1:0] = 2'b00;
    end

    // Advance the address pair on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            npc_q  <= AW'(4);
            skip_q <= 1'b0;
        end else if (step_i) begin
            pc_q   <= npc_q;
            npc_q  <= npc_d;
            skip_q <= skip_d;
        end
    end

    assign fetch_pc_o = pc_q;
    assign next_pc_o  = npc_q;
    assign annul_o    = skip_q;
    assign link_o     = seq_pc;
endmodule

// File: rtl/pcseq_chk.sv
// Checker for the sequencer, bound onto every pcseq_top instance.
module pcseq_chk
    import pcseq_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          step_i,
    input logic          exc_i,
    input logic [AW-1:0] fetch_pc_o,
    input logic [AW-1:0] next_pc_o,
    input logic          annul_o,
    input logic [AW-1:0] epc_o
);
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> fetch_pc_o == $past(next_pc_o));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(fetch_pc_o) && $stable(next_pc_o)));

    p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc_o[1:0] == 2'b00);

    p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !annul_o && exc_i) |=> (next_pc_o == EXC_VEC && annul_o));

    p_annul_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && annul_o) |=> (!annul_o && next_pc_o == $past(next_pc_o) + 32'd4));

    p_epc_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && annul_o) |=> $stable(epc_o));
endmodule

bind pcseq_top pcseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_i),
    .exc_i     (exc_i),
    .fetch_pc_o(fetch_pc_o),
    .next_pc_o (next_pc_o),
    .annul_o   (annul_o),
    .epc_o     (epc_o)
);

// File: tb/pcseq_top_bench.sv
module pcseq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [2:0]  cls_i = '0;
    logic        cond_i = 1'b0;
    logic [15:0] imm_i = '0;
    logic [25:0] jidx_i = '0;
    logic [31:0] jreg_i = '0;
    logic        exc_i = 1'b0;
    logic [31:0] fetch_pc_o, next_pc_o, epc_o, link_o;
    logic        annul_o;

    always #5 clk = ~clk;

    pcseq_top u_pcseq_top (.*);

    typedef struct packed {
        logic [31:0] pc, npc, epc;
        logic        skip;
        logic [7:0]  req;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0, n_bad = 0;
    logic [31:0] m_pc, m_npc, m_epc;
    logic        m_skip;
    bit          done = 0;

    task automatic cmp(input exp_t e, input string tag);
        n_chk++;
        if (fetch_pc_o !== e.pc || next_pc_o !== e.npc || annul_o !== e.skip || epc_o !== e.epc) begin
            n_bad++;
            $display("FAIL %s: got pc=%h npc=%h annul=%b epc=%h exp pc=%h npc=%h annul=%b epc=%h",
                     tag, fetch_pc_o, next_pc_o, annul_o, epc_o, e.pc, e.npc, e.skip, e.epc);
        end
    endtask

    // Driver: apply one step and push the expected state behind it.
    task automatic do_step(input logic [2:0] c, input logic cd, input logic [15:0] im,
                           input logic [25:0] ji, input logic [31:0] jr, input logic ex,
                           input logic [7:0] req);
        logic [31:0] seq, nn;
        logic        ns;
        exp_t        e;
        @(negedge clk);
        cls_i = c; cond_i = cd; imm_i = im; jidx_i = ji; jreg_i = jr; exc_i = ex; step_i = 1'b1;
        seq = m_npc + 32'd4; nn = seq; ns = 1'b0;
        if (!m_skip) begin
            if (ex) begin
                m_epc = (m_pc + 32'd4) | ((m_npc != m_pc + 32'd4) ? 32'd2 : 32'd0);
                nn = 32'h3C; ns = 1'b1;
            end else begin
                case (c)
                    3'd1: if (cd) nn = seq + {{14{im[15]}}, im, 2'b00} - 32'd4;
                    3'd2: if (cd) nn = seq + {{14{im[15]}}, im, 2'b00} - 32'd4; else ns = 1'b1;
                    3'd3: nn = {m_npc[31:28], ji, 2'b00};
                    3'd4: nn = jr;
                    default: nn = seq;
                endcase
            end
        end
        m_pc = m_npc; m_npc = {nn[31:2], 2'b00}; m_skip = ns;
        e.pc = m_pc; e.npc = m_npc; e.epc = m_epc; e.skip = m_skip; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        step_i = 1'b0; exc_i = 1'b0;
    endtask

    // Monitor: after each stepping edge, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            if (step_i && rst_n) begin
                #2;
                if (sb.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL scoreboard: got step with no expected item, exp queued item");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    cmp(e, $sformatf("R%0d step", e.req));
                end
            end
        end
    end

    task automatic now_chk(input string tag);
        exp_t e;
        e.pc = m_pc; e.npc = m_npc; e.epc = m_epc; e.skip = m_skip; e.req = 0;
        cmp(e, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pc = 0; m_npc = 4; m_epc = 0; m_skip = 0;
        @(negedge clk);
        now_chk("R1 reset state");
        // R10: link output
        n_chk++;
        if (link_o !== 32'd8) begin n_bad++; $display("FAIL R10 link got %h exp %h", link_o, 32'd8); end
        do_step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 8'd2);         // R2 plain
        repeat (2) @(negedge clk);
        now_chk("R2 hold without step");
        do_step(3'd1, 1, 16'h0004, 26'h0, 32'h0, 0, 8'd3);      // R3 taken
        do_step(3'd1, 0, 16'h0040, 26'h0, 32'h0, 0, 8'd3);      // R3 not taken
        do_step(3'd1, 1, 16'hFFFE, 26'h0, 32'h0, 0, 8'd3);      // R3 backward
        do_step(3'd4, 0, 16'h0, 26'h0, 32'hA000_1003, 0, 8'd6); // R6, R7 masked
        do_step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 8'd6);
        do_step(3'd3, 0, 16'h0, 26'h012_3456, 32'h0, 0, 8'd5); // R5 keeps nibble A
        do_step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 8'd5);
        n_chk++;
        if (link_o !== next_pc_o + 32'd4) begin
            n_bad++; $display("FAIL R10 link got %h exp %h", link_o, next_pc_o + 32'd4);
        end
        do_step(3'd2, 1, 16'h0010, 26'h0, 32'h0, 0, 8'd4);      // R4 taken
        do_step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 8'd4);
        do_step(3'd2, 0, 16'h0010, 26'h0, 32'h0, 0, 8'd4);      // R4 annul
        do_step(3'd4, 1, 16'h0, 26'h0, 32'h0000_0800, 1, 8'd9); // R9 ignored
        do_step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 8'd9);
        do_step(3'd0, 0, 16'h0, 26'h0, 32'h0, 1, 8'd8);         // R8 not in slot
        do_step(3'd4, 0, 16'h0, 26'h0, 32'h0000_0400, 0, 8'd8); // annulled after entry
        do_step(3'd1, 1, 16'h0008, 26'h0, 32'h0, 0, 8'd8);      // branch, then fault in slot
        do_step(3'd3, 0, 16'h0, 26'h3FF_FFFF, 32'h0, 1, 8'd8);  // R8 slot flag, priority
        do_step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 8'd8);
        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard: %0d items left, exp 0", sb.size());
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run incomplete got %0d cycles exp completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule